// File: doc/BRIEF.md
# KP-Qualified Tone Reporting Controller

This block sits between a two-channel multifrequency tone detector and a host-facing result queue. Each channel supplies a presence flag and a 6-bit tone code. A legal code has exactly two bits set, which gives two of the six R1 frequencies. The controller decides which detections become reports. A channel can be switched off. It can also be told to stay silent until a KP start tone has been seen, and KP itself has to stay present for a qualification time that is set per channel. Each accepted tone becomes one byte that carries the channel number and the tone, in either a numeric code or the raw frequency pattern.

Time is counted in milliseconds from a tick. The tick comes from the system clock through a prescaler that software can program. Bytes go into a small queue that drains through a valid/ready stream. The detector side has no back-pressure. A detection is seen on every cycle it is present. A report that finds the queue full is discarded. Once out_valid is high, it stays high and out_data stays fixed until the consumer takes the byte with out_ready.

Top module: `mf_report_ctrl`

## Requirements
- R1: When a channel's enable bit is low, that channel queues nothing, its KP timer is cleared and its gate is closed. After it is enabled again, a gated channel needs a new KP.
- R2: A millisecond tick fires once every cfg_prescale clock cycles. A value of 0 acts as 1. All KP timing counts these ticks.
- R3: KP is the pair of bit 2 (1100 Hz) and bit 5 (1700 Hz). With the channel's long bit clear, KP is accepted once 30 ticks have passed while it is continuously present. It is then reported once.
- R4: With the long bit set, KP is accepted only after 55 ticks of continuous presence.
- R5: The KP timer starts again from zero whenever the KP code is absent for even one cycle before acceptance.
- R6: With the channel's gate bit set, tones other than KP are not reported until a KP has been accepted on that channel. With the gate bit clear, every legal tone is reported.
- R7: Reporting an end tone closes the channel's gate. An end tone is any pair that contains bit 5 (1700 Hz) other than KP.
- R8: Each presence gives at most one report. A new report needs det_valid to go low first, and a code change without an idle cycle is not reported. A code that does not have exactly two bits set counts as absent.
- R9: Byte bit 7 is the channel (0 = first, 1 = second). In binary format (cfg_binary = 1), bits 3:0 hold the tone value and bits 6:4 are zero. The values are: 1..9 = digits 1..9, 10 = digit 0, 11 = KP, 12 = 1500+1700 Hz, 13 = 900+1700 Hz, 14 = 1300+1700 Hz, 15 = 700+1700 Hz.
- R10: In 2-of-6 format (cfg_binary = 0), bits 5:0 hold the detector pattern (bit 0 = 700 Hz up to bit 5 = 1700 Hz) and bit 6 is zero.
- R11: When both channels report in the same cycle, the first channel's byte is queued first and the second channel's byte is queued on the next cycle.
- R12: A report appears on out_valid two cycles after the first detector cycle that qualifies it. The queue holds FIFO_DEPTH bytes in order. A report arriving while it is full is dropped. out_data holds steady while out_valid is high and out_ready is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_prescale | input | PRESCALE_W | Clock cycles per millisecond tick |
| cfg_binary | input | 1 | 1 = binary tone value, 0 = 2-of-6 pattern |
| cfg_enable | input | 2 | Per-channel enable |
| cfg_kp_long | input | 2 | Per-channel KP time select (1 = 55 ms, 0 = 30 ms) |
| cfg_kp_gate | input | 2 | Per-channel KP gating enable |
| det_valid | input | 2 | Per-channel tone presence from the detector |
| det_code | input | 12 | Per-channel 6-bit tone pattern, channel 0 in bits 5:0 |
| out_valid | output | 1 | Result byte available |
| out_ready | input | 1 | Consumer accepts the byte |
| out_data | output | 8 | Result byte |

## Verification
The hardest state to reach is a gated channel whose KP has been present for almost the full qualification window, followed by a one-cycle dropout or a channel disable. Only exact tick counting tells a correct timer restart apart from one that resumes. The stimulus holds KP for lengths chosen just under and just over 30 and 55 ticks at two prescaler settings. It also inserts single idle cycles inside long holds and toggles enable after a gate has opened. Separately, the output is stalled while six reports arrive, which forces the drop-on-full rule, and a same-cycle report on both channels exercises the ordering register.

// File: rtl/mf_report_pkg.sv
`timescale 1ns/1ps
package mf_report_pkg;
  localparam int FREQS  = 6;
  localparam int NUM_CH = 2;

  typedef logic [FREQS-1:0] pair_t;
  typedef logic [7:0]       rbyte_t;

  // start tone: 1100 Hz + 1700 Hz
  localparam pair_t KP_PAIR = 6'b100100;

  // Numeric value of a two-of-six pair: digits from the triangular index
  // of the lower five frequencies, 1700 Hz pairs from a small mapping.
  function automatic logic [3:0] pair_value(pair_t p);
    int lo;
    int hi;
    logic [3:0] v;
    lo = 0;
    hi = 0;
    for (int i = FREQS - 1; i >= 0; i--) if (p[i]) lo = i;
    for (int i = 0; i < FREQS; i++) if (p[i]) hi = i;
    if (hi == FREQS - 1) begin
      case (lo)
        0:       v = 4'd15;
        1:       v = 4'd13;
        2:       v = 4'd11;
        3:       v = 4'd14;
        default: v = 4'd12;
      endcase
    end else begin
      v = 4'((hi * (hi - 1)) / 2 + lo + 1);
    end
    return v;
  endfunction

  function automatic rbyte_t make_byte(pair_t p, logic ch, logic binary);
    rbyte_t b;
    if (binary) b = {ch, 3'b000, pair_value(p)};
    else        b = {ch, 1'b0, p};
    return b;
  endfunction
endpackage

// File: rtl/mf_ms_tick.sv
`timescale 1ns/1ps
module mf_ms_tick #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] prescale,
  output logic         tick
);
  logic [W-1:0] cnt;
  logic [W-1:0] last;

  always_comb begin
    last = (prescale == '0) ? '0 : prescale - W'(1);
    tick = (cnt >= last);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + W'(1);
  end
endmodule

// File: rtl/mf_kp_chan.sv
`timescale 1ns/1ps
module mf_kp_chan
  import mf_report_pkg::*;
#(
  parameter int SHORT_MS = 30,
  parameter int LONG_MS  = 55
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  tick,
  input  logic  enable,
  input  logic  kp_long,
  input  logic  kp_gate,
  input  logic  det_valid,
  input  pair_t det_code,
  output logic  rep_valid,
  output pair_t rep_pair
);
  localparam int MAXT = (LONG_MS > SHORT_MS) ? LONG_MS : SHORT_MS;
  localparam int CW   = $clog2(MAXT + 1);

  logic          present, is_kp, is_end, kp_here, kp_ok, other_ok, fire;
  logic          done, gate_open;
  logic [CW-1:0] cnt, limit;

  always_comb begin
    present  = enable && det_valid && ($countones(det_code) == 2);
    is_kp    = (det_code == KP_PAIR);
    is_end   = det_code[FREQS-1] && !is_kp;
    limit    = kp_long ? CW'(LONG_MS) : CW'(SHORT_MS);
    kp_here  = present && is_kp;
    kp_ok    = kp_here && (cnt >= limit);
    other_ok = present && !is_kp && (!kp_gate || gate_open);
    fire     = !done && (kp_ok || other_ok);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) begin
      cnt       <= '0;
      done      <= 1'b0;
      gate_open <= 1'b0;
      rep_valid <= 1'b0;
      rep_pair  <= '0;
    end else begin
      if (!kp_here)                 cnt <= '0;
      else if (tick && cnt < limit) cnt <= cnt + CW'(1);
      done <= present && (done || fire);
      if (fire && is_kp)       gate_open <= 1'b1;
      else if (fire && is_end) gate_open <= 1'b0;
      rep_valid <= fire;
      rep_pair  <= det_code;
    end
  end
endmodule

// File: rtl/mf_report_fifo.sv
`timescale 1ns/1ps
module mf_report_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_valid,
  input  logic [W-1:0] wr_data,
  output logic         rd_valid,
  input  logic         rd_ready,
  output logic [W-1:0] rd_data
);
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNTW = $clog2(DEPTH + 1);

  logic [W-1:0]    mem [DEPTH];
  logic [AW-1:0]   wr_ptr, rd_ptr;
  logic [CNTW-1:0] count;
  logic            push, pop;

  always_comb begin
    rd_valid = (count != '0);
    push     = wr_valid && (count != CNTW'(DEPTH));
    pop      = rd_valid && rd_ready;
    rd_data  = mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + AW'(1);
      if (pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + AW'(1);
      count <= count + CNTW'(push) - CNTW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wr_data;
  end
endmodule

// File: rtl/mf_report_ctrl.sv
`timescale 1ns/1ps
module mf_report_ctrl
  import mf_report_pkg::*;
#(
  parameter int PRESCALE_W = 16,
  parameter int KP_SHORT_MS = 30,
  parameter int KP_LONG_MS  = 55,
  parameter int FIFO_DEPTH  = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [PRESCALE_W-1:0] cfg_prescale,
  input  logic                  cfg_binary,
  input  logic [1:0]            cfg_enable,
  input  logic [1:0]            cfg_kp_long,
  input  logic [1:0]            cfg_kp_gate,
  input  logic [1:0]            det_valid,
  input  logic [11:0]           det_code,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [7:0]            out_data
);
  logic                        tick;
  logic [NUM_CH-1:0]           rep_v;
  logic [NUM_CH-1:0][FREQS-1:0] rep_pairs;
  rbyte_t                      enc [NUM_CH];
  logic                        pend_v, second_v, wr_v;
  rbyte_t                      pend_d, second_d, wr_d;

  mf_ms_tick #(.W(PRESCALE_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .prescale(cfg_prescale), .tick(tick)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    mf_kp_chan #(.SHORT_MS(KP_SHORT_MS), .LONG_MS(KP_LONG_MS)) u_chan (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .enable(cfg_enable[c]), .kp_long(cfg_kp_long[c]), .kp_gate(cfg_kp_gate[c]),
      .det_valid(det_valid[c]), .det_code(det_code[c*FREQS +: FREQS]),
      .rep_valid(rep_v[c]), .rep_pair(rep_pairs[c])
    );
    assign enc[c] = make_byte(rep_pairs[c], 1'(c), cfg_binary);
  end

  // one write per cycle; a second simultaneous report waits one cycle
  always_comb begin
    wr_v = pend_v || (rep_v != '0);
    if (pend_v) begin
      wr_d     = pend_d;
      second_v = rep_v[0] || rep_v[1];
      second_d = rep_v[0] ? enc[0] : enc[1];
    end else if (rep_v[0]) begin
      wr_d     = enc[0];
      second_v = rep_v[1];
      second_d = enc[1];
    end else begin
      wr_d     = enc[1];
      second_v = 1'b0;
      second_d = enc[1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_v <= 1'b0;
      pend_d <= '0;
    end else begin
      pend_v <= second_v;
      pend_d <= second_d;
    end
  end

  mf_report_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_fifo (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_v), .wr_data(wr_d),
    .rd_valid(out_valid), .rd_ready(out_ready), .rd_data(out_data)
  );
endmodule

// File: rtl/mf_report_ctrl_chk.sv
`timescale 1ns/1ps
module mf_report_ctrl_chk (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       cfg_enable,
  input logic [1:0]       det_valid,
  input logic [11:0]      det_code,
  input logic [1:0]       rep_v,
  input logic [1:0][5:0]  rep_pairs,
  input logic             pend_v,
  input logic             out_valid,
  input logic             out_ready,
  input logic [7:0]       out_data
);
  assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  assert_start_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> ($past(rep_v) != 2'b00) || $past(pend_v));

  assert_order_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rep_v[0] && rep_v[1] |=> pend_v);

  for (genvar c = 0; c < 2; c++) begin : g_chk
    assert_disabled_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(cfg_enable[c]) |-> !rep_v[c]);

    assert_once_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rep_v[c] |=> !rep_v[c]);

    assert_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rep_v[c] |-> $countones(rep_pairs[c]) == 2);

    assert_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rep_v[c] |-> $past(det_valid[c]) && ($past(det_code[c*6 +: 6]) == rep_pairs[c]));
  end
endmodule

bind mf_report_ctrl mf_report_ctrl_chk i_chk (
  .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .det_valid(det_valid),
  .det_code(det_code), .rep_v(rep_v), .rep_pairs(rep_pairs), .pend_v(pend_v),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
);

// File: tb/test_mf_report_ctrl.sv
`timescale 1ns/1ps
module test_mf_report_ctrl;
  localparam int DEPTH = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] cfg_prescale;
  logic        cfg_binary;
  logic [1:0]  cfg_enable, cfg_kp_long, cfg_kp_gate, det_valid;
  logic [11:0] det_code;
  logic        out_valid, out_ready;
  logic [7:0]  out_data;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // reference state
  int       m_pc;
  int       m_cnt [2];
  bit       m_done [2], m_gate [2], m_rv [2];
  bit [5:0] m_rp [2];
  bit       m_pv;
  bit [7:0] m_pd;
  bit [7:0] mq [$];
  bit [7:0] got [$];

  always #2 clk = ~clk;

  mf_report_ctrl #(.FIFO_DEPTH(DEPTH)) i_mf_report_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_prescale(cfg_prescale), .cfg_binary(cfg_binary),
    .cfg_enable(cfg_enable), .cfg_kp_long(cfg_kp_long), .cfg_kp_gate(cfg_kp_gate),
    .det_valid(det_valid), .det_code(det_code), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data)
  );

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic bit [3:0] bval(bit [5:0] p);
    case (p)
      6'b000011: return 4'd1;
      6'b000101: return 4'd2;
      6'b000110: return 4'd3;
      6'b001001: return 4'd4;
      6'b001010: return 4'd5;
      6'b001100: return 4'd6;
      6'b010001: return 4'd7;
      6'b010010: return 4'd8;
      6'b010100: return 4'd9;
      6'b011000: return 4'd10;
      6'b100100: return 4'd11;
      6'b110000: return 4'd12;
      6'b100010: return 4'd13;
      6'b101000: return 4'd14;
      default:   return 4'd15;
    endcase
  endfunction

  function automatic bit [7:0] benc(bit [5:0] p, int c);
    bit [7:0] b;
    b = cfg_binary ? {4'b0000, bval(p)} : {2'b00, p};
    b[7] = (c == 1);
    return b;
  endfunction

  task automatic model_update();
    int lim, klim;
    bit tick, full, pres, kp, kpok, oth, f;
    bit [5:0] code;
    bit [7:0] reqs [$];
    lim  = (cfg_prescale == 0) ? 0 : int'(cfg_prescale) - 1;
    tick = (m_pc >= lim);
    if (m_pv) reqs.push_back(m_pd);
    for (int c = 0; c < 2; c++) if (m_rv[c]) reqs.push_back(benc(m_rp[c], c));
    full = (mq.size() == DEPTH);
    if (mq.size() > 0 && out_ready) void'(mq.pop_front());
    if (reqs.size() > 0 && !full) mq.push_back(reqs[0]);
    m_pv = (reqs.size() > 1);
    if (m_pv) m_pd = reqs[1];
    for (int c = 0; c < 2; c++) begin
      code = det_code[c*6 +: 6];
      if (!cfg_enable[c]) begin
        m_cnt[c] = 0; m_done[c] = 0; m_gate[c] = 0; m_rv[c] = 0;
      end else begin
        klim = cfg_kp_long[c] ? 55 : 30;
        pres = det_valid[c] && ($countones(code) == 2);
        kp   = (code == 6'b100100);
        kpok = pres && kp && (m_cnt[c] >= klim);
        oth  = pres && !kp && (!cfg_kp_gate[c] || m_gate[c]);
        f    = !m_done[c] && (kpok || oth);
        if (!(pres && kp)) m_cnt[c] = 0;
        else if (tick && m_cnt[c] < klim) m_cnt[c]++;
        m_done[c] = pres && (m_done[c] || f);
        if (f && kp) m_gate[c] = 1;
        else if (f && code[5]) m_gate[c] = 0;
        m_rv[c] = f;
        m_rp[c] = code;
      end
    end
    m_pc = tick ? 0 : m_pc + 1;
  endtask

  task automatic step();
    if (out_valid && out_ready) got.push_back(out_data);
    model_update();
    @(posedge clk);
    #1;
    chk(out_valid === (mq.size() != 0), "R12 out_valid vs model", int'(out_valid), int'(mq.size() != 0));
    if (mq.size() != 0)
      chk(out_data === mq[0], "R9 R10 out_data vs model", int'(out_data), int'(mq[0]));
    @(negedge clk);
  endtask

  task automatic run(int n);
    repeat (n) step();
  endtask

  task automatic hold(int ch, bit [5:0] code, int n);
    det_valid[ch] = 1'b1;
    det_code[ch*6 +: 6] = code;
    run(n);
    det_valid[ch] = 1'b0;
    det_code[ch*6 +: 6] = '0;
  endtask

  task automatic expect_bytes(string tag, bit [7:0] e [$]);
    run(5);
    chk(got.size() == e.size(), {tag, " byte count"}, got.size(), e.size());
    for (int i = 0; i < e.size() && i < got.size(); i++)
      chk(got[i] == e[i], {tag, " byte value"}, int'(got[i]), int'(e[i]));
    got.delete();
  endtask

  task automatic expect_none(string tag);
    run(5);
    chk(got.size() == 0, {tag, " no report"}, got.size(), 0);
    got.delete();
  endtask

  initial begin
    rst_n = 1'b0;
    cfg_prescale = 16'd4; cfg_binary = 1'b1;
    cfg_enable = 2'b11; cfg_kp_long = 2'b00; cfg_kp_gate = 2'b00;
    det_valid = '0; det_code = '0; out_ready = 1'b1;
    m_pc = 0; m_pv = 0; m_pd = 0;
    for (int c = 0; c < 2; c++) begin
      m_cnt[c] = 0; m_done[c] = 0; m_gate[c] = 0; m_rv[c] = 0; m_rp[c] = 0;
    end
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(out_valid == 1'b0, "R12 reset out_valid", int'(out_valid), 0);
    rst_n = 1'b1;
    run(3);

    // ungated, binary: digit 5 on channel 0
    hold(0, 6'b001010, 5);
    expect_bytes("R9 R6 digit5 ch0", '{8'h05});
    // code change without idle gives no second report
    det_valid[0] = 1'b1; det_code[5:0] = 6'b001001; run(5);
    det_code[5:0] = 6'b001100; run(5);
    det_valid[0] = 1'b0; det_code[5:0] = '0;
    expect_bytes("R8 change without idle", '{8'h04});
    hold(0, 6'b000001, 5);
    hold(0, 6'b000111, 5);
    expect_none("R8 illegal codes");

    // 2-of-6 format
    cfg_binary = 1'b0;
    hold(1, 6'b011000, 4);
    expect_bytes("R10 digit0 ch1", '{8'h98});
    hold(0, 6'b100001, 3);
    expect_bytes("R10 end tone ch0", '{8'h21});

    // disabled channel
    cfg_binary = 1'b1; cfg_enable = 2'b01;
    hold(1, 6'b001010, 5);
    expect_none("R1 disabled ch1");

    // gating on channel 0, 30 ms KP
    cfg_enable = 2'b00; run(1);
    cfg_enable = 2'b11; cfg_kp_gate = 2'b01;
    hold(0, 6'b010001, 5);
    expect_none("R6 tone before KP");
    hold(0, 6'b100100, 110);
    expect_none("R3 KP too short");
    hold(0, 6'b100100, 130);
    expect_bytes("R3 KP accepted", '{8'h0B});
    hold(0, 6'b000101, 4);
    expect_bytes("R6 digit after KP", '{8'h02});
    hold(0, 6'b110000, 4);
    expect_bytes("R9 end tone", '{8'h0C});
    hold(0, 6'b000110, 4);
    expect_none("R7 gate closed after end tone");

    // timer restart
    hold(0, 6'b100100, 110);
    run(1);
    hold(0, 6'b100100, 110);
    expect_none("R5 restart after dropout");

    // 55 ms on channel 1
    cfg_kp_gate = 2'b10; cfg_kp_long = 2'b10;
    hold(1, 6'b100100, 200);
    expect_none("R4 KP under 55");
    hold(1, 6'b100100, 200);
    run(1);
    hold(1, 6'b100100, 100);
    expect_none("R5 long restart");
    hold(1, 6'b100100, 230);
    expect_bytes("R4 KP long accepted", '{8'h8B});
    hold(1, 6'b010010, 4);
    expect_bytes("R9 digit8 ch1", '{8'h88});
    cfg_enable = 2'b01; run(1);
    cfg_enable = 2'b11;
    hold(1, 6'b010010, 4);
    expect_none("R1 gate cleared by disable");

    // prescaler 2
    cfg_prescale = 16'd2; cfg_kp_long = 2'b00; cfg_kp_gate = 2'b01;
    hold(0, 6'b100100, 58);
    expect_none("R2 KP under 30 ticks at prescale 2");
    hold(0, 6'b100100, 65);
    expect_bytes("R2 KP at prescale 2", '{8'h0B});
    hold(0, 6'b110000, 3);
    expect_bytes("R7 end tone", '{8'h0C});
    cfg_prescale = 16'd4;

    // collision
    cfg_kp_gate = 2'b00;
    det_valid = 2'b11; det_code = {6'b010100, 6'b000011};
    run(4);
    det_valid = 2'b00; det_code = '0;
    expect_bytes("R11 same cycle order", '{8'h01, 8'h89});

    // back-pressure and overflow
    out_ready = 1'b0;
    hold(0, 6'b000011, 2); run(1);
    hold(0, 6'b000101, 2); run(1);
    hold(0, 6'b000110, 2); run(1);
    hold(0, 6'b001001, 2); run(1);
    hold(0, 6'b001010, 2); run(1);
    hold(0, 6'b001100, 2); run(6);
    chk(out_valid == 1'b1 && out_data == 8'h01, "R12 stalled head", int'(out_data), 8'h01);
    out_ready = 1'b1;
    run(4);
    expect_bytes("R12 full queue drops", '{8'h01, 8'h02, 8'h03, 8'h04});

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog R12: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule